// File: doc/BRIEF.md
# LCD Frame Clock Prescaler

This block produces the timing enable for a segment LCD controller. It counts events from one of two sources. The first is the system clock itself, where every cycle is one event. The second is an external oscillator pin, where each rising edge seen through a synchroniser is one event. A free-running binary counter divides the event stream by a power of two, and a 3-bit code picks that ratio. The set of ratios skips divide-by-32. A second stage then divides the chosen tap rate by a further whole number from 1 to 8.

The result is a one-cycle `frame_tick` pulse in the system-clock domain. It is the only enable the downstream LCD timing logic uses. When either code changes, both counters clear. The first period after a change is therefore always a full period. A run enable parks the whole chain at zero. There is no data stream, so every pin is a plain control or status level.

Top module: `lcd_frame_prescaler`

## Requirements
- R1: While `rst_n` is low, and in the cycle after reset is sampled, `frame_tick` is low.
- R2: With `src_sel` = 0, every system clock cycle is one count event. Consecutive `frame_tick` pulses are then exactly tap ratio × divide ratio cycles apart.
- R3: `tap_sel` codes 0,1,2,3,4,5,6,7 select tap ratios 16,64,128,256,512,1024,2048,4096. No code gives 32.
- R4: `div_sel` code N gives a divide ratio of N+1, so code 0 passes every tap pulse and code 7 passes one in eight.
- R5: With `src_sel` = 1, only rising edges of `ext_osc` that have passed a two-flop synchroniser count. For an oscillator of period P system cycles, ticks are P × tap ratio × divide ratio cycles apart.
- R6: `frame_tick` is high for exactly one system-clock cycle per divided period.
- R7: A change on `tap_sel` or `div_sel` clears both counters in the first clock edge that sees it. With `src_sel` = 0, the first tick then becomes visible after tap × divide + 1 edges.
- R8: While `run_en` is low, no tick is produced and the counters stay at zero. With `src_sel` = 0, the first tick after `run_en` rises becomes visible after tap × divide edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enables counting; low holds all counters at zero |
| src_sel | input | 1 | 0: count system clock cycles, 1: count external oscillator edges |
| ext_osc | input | 1 | External oscillator pin, asynchronous |
| tap_sel | input | 3 | Prescaler tap code |
| div_sel | input | 3 | Second-stage divide code (ratio = code + 1) |
| frame_tick | output | 1 | One-cycle enable for the LCD timing logic |

## Verification
The tick spacing is measured for several pairs of tap and divide codes on the system clock:
- the smallest ratio, which checks the low end of the tap list;
- code 1, which yields 64 and so shows that 32 is skipped;
- the largest tap, which checks the top of the tap list;
- several divide codes, which separate the N+1 rule from an off-by-one.

A run from a slow external oscillator shows that spacing follows oscillator edges and not system cycles. The delay from a code change, and from re-enabling, to the first tick is counted edge by edge. This separates a full restart from a runt period. Each observed pulse is also checked to be a single cycle wide.

// File: rtl/lcd_presc_pkg.sv
package lcd_presc_pkg;
  localparam int unsigned PRESC_W = 12;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned SYNC_N  = 2;

  // Log2 of the tap ratio for a code: 16 for code 0, then 64 upward.
  function automatic int unsigned tap_log2(input logic [CODE_W-1:0] code);
    if (code == '0) return 4;
    return 32'(code) + 5;
  endfunction
endpackage

// File: rtl/lcd_src_event.sv
module lcd_src_event
  import lcd_presc_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic ext_osc,
  output logic src_ev
);
  localparam int unsigned HW = STAGES + 1;

  logic [HW-1:0] sh_q;
  logic          ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[HW-2:0], ext_osc};
  end

  assign ext_rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign src_ev   = src_sel ? ext_rise : 1'b1;

  // R2
  sysclk_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_sel |-> src_ev);

  // R5
  ext_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && $past(src_sel) && $past(src_ev)) |-> !src_ev);
endmodule

// File: rtl/lcd_tap_counter.sv
module lcd_tap_counter
  import lcd_presc_pkg::*;
#(
  parameter int unsigned CW = PRESC_W,
  parameter int unsigned SW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ev,
  input  logic [SW-1:0] tap_sel,
  output logic          tap_pulse
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CW; i++)
      if (i < int'(tap_log2(tap_sel))) mask[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (ev)       cnt_q <= cnt_q + 1'b1;
  end

  assign tap_pulse = ev & ((cnt_q & mask) == mask);

  // R2
  tap_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_pulse |-> ev);

  // R8
  cnt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/lcd_div_stage.sv
module lcd_div_stage
  import lcd_presc_pkg::*;
#(
  parameter int unsigned SW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tap_pulse,
  input  logic [SW-1:0] div_sel,
  output logic          tick
);
  logic [SW-1:0] dcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      dcnt_q <= '0;
      tick   <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (tap_pulse) begin
        if (dcnt_q == div_sel) begin
          dcnt_q <= '0;
          tick   <= 1'b1;
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  // R4
  dcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    dcnt_q <= div_sel);

  // R4
  tick_after_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick) |-> $past(tap_pulse));
endmodule

// File: rtl/lcd_frame_prescaler.sv
module lcd_frame_prescaler
  import lcd_presc_pkg::*;
#(
  parameter int unsigned CW = PRESC_W,
  parameter int unsigned SW = CODE_W,
  parameter int unsigned STAGES = SYNC_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          src_sel,
  input  logic          ext_osc,
  input  logic [SW-1:0] tap_sel,
  input  logic [SW-1:0] div_sel,
  output logic          frame_tick
);
  logic [SW-1:0] tap_q, div_q;
  logic          code_chg, clr, src_ev, tap_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q <= tap_sel;
      div_q <= div_sel;
    end else begin
      tap_q <= tap_sel;
      div_q <= div_sel;
    end
  end

  assign code_chg = (tap_sel != tap_q) || (div_sel != div_q);
  assign clr      = !run_en || code_chg;

  lcd_src_event #(.STAGES(STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_osc(ext_osc), .src_ev(src_ev));

  lcd_tap_counter #(.CW(CW), .SW(SW)) u_tap (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev(src_ev),
    .tap_sel(tap_sel), .tap_pulse(tap_pulse));

  lcd_div_stage #(.SW(SW)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tap_pulse(tap_pulse),
    .div_sel(div_sel), .tick(frame_tick));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !frame_tick);

  // R6
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> !frame_tick);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !frame_tick);

  // R7
  change_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> !frame_tick);
endmodule

// File: tb/test_lcd_frame_prescaler.sv
module test_lcd_frame_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       src_sel = 1'b0;
  logic       ext_osc = 1'b0;
  logic [2:0] tap_sel = 3'd0;
  logic [2:0] div_sel = 3'd0;
  logic       frame_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  lcd_frame_prescaler i_lcd_frame_prescaler (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
    .ext_osc(ext_osc), .tap_sel(tap_sel), .div_sel(div_sel),
    .frame_tick(frame_tick));

  always #10 clk = ~clk;           // 50 MHz
  always #60 ext_osc = ~ext_osc;   // period of 6 system cycles, edges on negedges

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=190000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int tap_ratio(input int code);
    return (code == 0) ? 16 : (1 << (code + 5));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Edges until frame_tick is visible at a negedge (limit returns -1).
  task automatic edges_to_tick(input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk); @(negedge clk);
      if (frame_tick) begin n = k; return; end
    end
  endtask

  // Skip one tick, check its width, then measure spacing to the next.
  task automatic measure(input string req, input int exp);
    int n, w;
    edges_to_tick(exp * 2 + 40, n);
    @(posedge clk); @(negedge clk);
    w = frame_tick;
    check("R6 width", w, 0);
    edges_to_tick(exp + 40, n);
    check(req, n + 1, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 tick in reset", frame_tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tick after reset", frame_tick, 0);
  endtask

  task automatic t_sysclk(input int t, input int d, input string req);
    @(negedge clk); tap_sel = 3'(t); div_sel = 3'(d); src_sel = 1'b0; run_en = 1'b1;
    measure(req, tap_ratio(t) * (d + 1));
  endtask

  task automatic t_ext;
    @(negedge clk); tap_sel = 3'd0; div_sel = 3'd1; src_sel = 1'b1; run_en = 1'b1;
    measure("R5 external spacing", 6 * 16 * 2);
    src_sel = 1'b0;
  endtask

  task automatic t_change;
    int n;
    @(negedge clk); src_sel = 1'b0; run_en = 1'b1; tap_sel = 3'd0; div_sel = 3'd3;
    repeat (30) @(negedge clk);
    tap_sel = 3'd1; div_sel = 3'd1;
    edges_to_tick(400, n);
    check("R7 restart after change", n, 64 * 2 + 1);
  endtask

  task automatic t_disable;
    int n, seen;
    @(negedge clk); tap_sel = 3'd0; div_sel = 3'd0; src_sel = 1'b0; run_en = 1'b0;
    seen = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (frame_tick) seen++;
    end
    check("R8 no tick while disabled", seen, 0);
    run_en = 1'b1;
    edges_to_tick(100, n);
    check("R8 first tick after enable", n, 16);
  endtask

  initial begin
    t_reset();
    t_sysclk(0, 0, "R2 R3 tap 16 div 1");
    t_sysclk(1, 0, "R3 tap code 1 is 64 not 32");
    t_sysclk(2, 0, "R3 tap 128");
    t_sysclk(0, 7, "R4 div code 7 is 8");
    t_sysclk(1, 2, "R4 div code 2 is 3");
    t_sysclk(7, 0, "R3 tap 4096");
    t_ext();
    t_change();
    t_disable();
    t_reset();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule